// File: doc/BRIEF.md
# Iterative Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands one multiplier bit per clock cycle. A single double-width register holds both the running partial sum and the multiplier that is still to be used. At the start of an operation the multiplier goes into the low half of that register and the high half is cleared. Each cycle looks at the register's least significant bit. When that bit is set, the multiplicand is added to the high half. The whole register then shifts right by one place, the adder carry enters at the top and the consumed bit drops off the bottom.

Control is through plain pins. A one-cycle `start` captures both operands when the block is not busy. `busy` stays high for exactly as many cycles as the operand has bits. `done` pulses for one cycle when the result is ready. The data interface has no back-pressure: the result does not wait for a consumer. It stays on `product` until the next accepted start, so a consumer may read it at the `done` pulse or at any time after it.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is low captures both operands. In the next cycle `busy` is 1 and `product` equals the multiplier zero-extended to double width, with the multiplier in the low half and zeros in the high half.
- R3: After an accepted start, `busy` stays high for exactly WIDTH cycles (32 by default). `done` is high in the cycle that follows the last of them.
- R4: When `done` is high, `product` equals the full unsigned double-width product of the two captured operands. This includes all-ones times all-ones, where the adder carry must reach the top bit.
- R5: `done` is high for a single cycle and is never high together with `busy`. While the block is not busy and no start is accepted, `product` does not change.
- R6: A `start` sampled while `busy` is high is ignored. The operation in progress keeps its operands and its timing.
- R7: A zero multiplicand or a zero multiplier gives a product of zero.
- R8: A `start` sampled in the same cycle that `done` is high is accepted and begins a new operation at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; acted on only when not busy |
| multiplicand | input | WIDTH | Operand added on each set multiplier bit, captured at start |
| multiplier | input | WIDTH | Operand scanned bit by bit, captured at start |
| busy | output | 1 | High during the WIDTH iteration cycles |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*WIDTH | Product register; final value held after done |

## Verification
Count the rising edge that samples `start` as edge 0. The loaded register value (R2) is visible after edge 0. `busy` is high after each of edges 0 through 31. `done` and the final product (R3, R4) appear after edge 32, and `done` falls after edge 33. The bench drives inputs on falling edges and samples on the falling edge after each of those exact rising edges. In every cycle of an operation it checks that `busy` is high and `done` is low. Starts injected during an operation, and starts issued in the `done` cycle, are checked against the same edge count, so a start that is ignored (R6) or accepted (R8) shows up directly in `done` timing and product value.

// File: rtl/mult_pkg.sv
package mult_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mult_state_t;
endpackage

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mult_state_t state_q, state_d;
  logic [CW-1:0] iter_q;

  assign busy = (state_q == ST_RUN);
  assign done = (state_q == ST_DONE);
  assign load = start && !busy;
  assign step = busy;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_RUN;
      ST_RUN:  if (iter_q == LAST) state_d = ST_DONE;
      ST_DONE: state_d = start ? ST_RUN : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load)      iter_q <= '0;
      else if (step) iter_q <= iter_q + 1'b1;
    end
  end
endmodule

// File: rtl/mult_cond_adder.sv
module mult_cond_adder #(
  parameter int WIDTH = 32
) (
  input  logic             en,
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] addend,
  output logic [WIDTH:0]   sum
);
  logic [WIDTH-1:0] gated;
  assign gated = en ? addend : '0;
  assign sum   = {1'b0, acc} + {1'b0, gated};
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  output logic [2*WIDTH-1:0] prod
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    prod_q;
  logic [WIDTH:0]   sum;
  logic [PW-1:0]    shifted;

  mult_cond_adder #(.WIDTH(WIDTH)) u_add (
    .en     (prod_q[0]),
    .acc    (prod_q[PW-1:WIDTH]),
    .addend (mcand_q),
    .sum    (sum)
  );

  assign shifted = {sum, prod_q[WIDTH-1:1]};
  assign prod    = prod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load) begin
      mcand_q <= mcand_in;
      prod_q  <= {{WIDTH{1'b0}}, mplier_in};
    end else if (step) begin
      prod_q  <= shifted;
    end
  end
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic load, step;

  mult_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  mult_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .mcand_in  (multiplicand),
    .mplier_in (multiplier),
    .prod      (product)
  );
endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && product == {{WIDTH{1'b0}}, $past(multiplier)}));

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 32'(WIDTH) && done));

  p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= 32'(WIDTH));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_cnt < 32'(WIDTH - 1)) |=> busy);
endmodule

bind shift_add_mult shift_add_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .busy         (busy),
  .done         (done),
  .product      (product)
);

// File: tb/tb_shift_add_mult.sv
module tb_shift_add_mult;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  shift_add_mult #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .multiplicand(mcand), .multiplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    return (2*W)'(a) * (2*W)'(b);
  endfunction

  task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Ends at the falling edge where done must be high (edge 32 after the start edge).
  task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit inject, input bit chained, input string req);
    bit timing_ok = 1'b1;
    if (!chained) @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(posedge clk); @(negedge clk);
    start = 1'b0; mcand = ~a; mplier = ~b;
    // R2: loaded register image
    check(busy && !done && product == {{W{1'b0}}, b}, "R2", product, {{W{1'b0}}, b});
    for (int i = 1; i <= W; i++) begin
      @(posedge clk); @(negedge clk);
      start = (inject && (i == 10 || i == 11)) ? 1'b1 : 1'b0;
      if (i < W && !(busy && !done)) timing_ok = 1'b0;
    end
    start = 1'b0;
    // R3: busy held WIDTH cycles, done after the last
    check(timing_ok && done && !busy, "R3", {62'd0, busy, done}, 64'd1);
    // R4/R6/R7/R8: final product
    check(product == ref_mul(a, b), req, product, ref_mul(a, b));
  endtask

  task automatic after_done;
    logic [2*W-1:0] held;
    held = product;
    @(posedge clk); @(negedge clk);
    check(!done && !busy, "R5 pulse", {62'd0, busy, done}, 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(product == held, "R5 hold", product, held);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && product == '0, "R1 in reset", product, '0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(!busy && !done && product == '0, "R1 after reset", product, '0);

    run_mult('0, '0, 1'b0, 1'b0, "R7 zero*zero");                  after_done();
    run_mult(32'h1234_5678, '0, 1'b0, 1'b0, "R7 x*0");             after_done();
    run_mult('0, 32'hDEAD_BEEF, 1'b0, 1'b0, "R7 0*x");             after_done();
    run_mult('1, '1, 1'b0, 1'b0, "R4 ones*ones");                  after_done();
    run_mult(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R4 msb*msb"); after_done();
    run_mult(32'd34, 32'd42, 1'b0, 1'b0, "R4 small");              after_done();
    run_mult('1, 32'd1, 1'b0, 1'b0, "R4 ones*1");                  after_done();
    run_mult(32'hCAFE_F00D, 32'h0BAD_F00D, 1'b1, 1'b0, "R6 start ignored"); after_done();
    run_mult('1, 32'h7, 1'b0, 1'b0, "R8 first");
    run_mult(32'h0001_0001, '1, 1'b0, 1'b1, "R8 back-to-back");    after_done();

    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (k % 8 == 3) ra = '1;
      if (k % 8 == 5) rb = {W{1'b1}} ^ (W'(1) << (k % W));
      run_mult(ra, rb, (k % 5 == 0), 1'b0, "R4 random");
    end
    after_done();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule